// File: doc/BRIEF.md
# Reservation-Station Scheduler with Result Broadcast Bus

This block is the scheduling core of an out-of-order pipeline that renames by copying values. Decoded instructions arrive in program order on a dispatch stream. Each instruction takes a free station of the matching unit class, and its two source operands are resolved at that moment. A source whose map entry is empty reads its value straight from the register file held inside the block. A source with a pending producer records that producer's tag instead. The destination register's map entry is then pointed at the new station. Because operands travel with the instruction, a later write to the same register never stalls dispatch, and a finishing instruction never waits for older readers.

Stations watch a single result bus. When a bus tag matches one of a station's pending source tags, the station takes the value. A station whose operands are both present requests issue, and the oldest such station is offered on the issue stream. Functional units are outside the block. They report completion per station on a done/result vector, and the block holds the result until the bus is free. When several stations hold results, the oldest one drives the bus. The register file is written, and the map entry cleared, only when that entry still names the finishing station. Instructions with no destination free their station without using the bus.

Back-pressure: an instruction is taken when `disp_valid` and `disp_ready` are both high at a clock edge. `disp_ready` depends only on `disp_class` and the station state, never on `disp_valid`. An issue is taken when `iss_valid` and `iss_ready` are both high at a clock edge. While `iss_ready` is low, the offered instruction stays in its station and may be offered again.

Top module: `rs_sched`

## Requirements
- R1: After reset every station is free, no bus broadcast or issue is offered, every map entry is 0, and register k holds 16*k.
- R2: The `disp_class` codes are 0 for ALU (one station, tag 1), 1 for load (one station, tag 2), 2 for store (one station, tag 3) and 3 for floating point (two stations, tags 4 and 5). Tag 0 means "ready". A station's index in `fu_done` is its tag minus 1. Dispatch takes the lowest-numbered free station of the class. `disp_ready` is low only when no station of that class is free.
- R3: A dispatch with `disp_has_dst` set writes the new station's tag into the map entry of `disp_dst` at that edge. This holds even when that entry already names another producer (no stall on write-after-write).
- R4: A source whose map entry is 0 captures the register-file value at dispatch. Otherwise the station keeps the tag, does not request issue, and takes the value from the first bus broadcast carrying that tag.
- R5: On a broadcast, the register file entry of the destination is written and its map entry cleared only if the map entry still equals the broadcast tag. Otherwise neither is changed.
- R6: A completion with no destination frees its station in the cycle after `fu_done` without driving the bus.
- R7: Among stations holding a result for a destination, the one dispatched earliest drives the bus (`cdb_valid`, `cdb_tag`, `cdb_value`). Each of the others keeps its result and drives the bus in a later cycle.
- R8: The issue stream offers the earliest-dispatched station whose operands are all present. An operand arriving on the bus in the same cycle counts as present, and its value is forwarded on `iss_opnd1`/`iss_opnd2`.
- R9: A station that frees itself in a cycle, by bus grant or by a store completion, can be allocated again by a dispatch in that same cycle.
- R10: A dispatch whose source map tag equals the tag on the bus in the same cycle captures the bus value and does not wait.
- R11: `fu_done` for a station that is free, not yet issued, or already done has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Dispatch request |
| disp_ready | output | 1 | A station of `disp_class` is free this cycle |
| disp_class | input | 2 | Unit class code (R2) |
| disp_op | input | OPW (4) | Opcode carried to issue |
| disp_has_dst | input | 1 | Instruction writes a register |
| disp_dst | input | RW (3) | Destination register |
| disp_src1 | input | RW (3) | First source register |
| disp_src2 | input | RW (3) | Second source register |
| iss_valid | output | 1 | An instruction is offered for execution |
| iss_ready | input | 1 | Functional units accept the offer |
| iss_tag | output | TAGW (3) | Tag of the offered station |
| iss_op | output | OPW (4) | Opcode of the offered instruction |
| iss_opnd1 | output | XLEN (16) | First operand value |
| iss_opnd2 | output | XLEN (16) | Second operand value |
| fu_done | input | NRS (5) | Per-station completion pulse |
| fu_result | input | NRS*XLEN (80) | Per-station result, station i in bits i*XLEN upward |
| cdb_valid | output | 1 | Result bus carries a broadcast |
| cdb_tag | output | TAGW (3) | Broadcasting station tag |
| cdb_value | output | XLEN (16) | Broadcast value |
| obs_reg | input | RW (3) | Register selected for observation |
| obs_tag | output | TAGW (3) | Map entry of `obs_reg` |
| obs_value | output | XLEN (16) | Register-file value of `obs_reg` |

## Verification
A wrong map entry shows on `obs_tag` one cycle after the dispatch or broadcast that set it, and it later shows as a missing or stale register-file write on `obs_value`. A station holding a wrong source tag either never raises `iss_valid` (the bench's watchdog runs out) or issues at once with the wrong `iss_opnd` values in the cycle after dispatch. Arbitration and age faults appear as a wrong `iss_tag` or `cdb_tag` in the first cycle where two candidates compete. The directed scenarios set up exactly those cycles.

// File: rtl/rs_sched_pkg.sv
package rs_sched_pkg;
  typedef enum logic [1:0] {
    UC_ALU   = 2'd0,
    UC_LOAD  = 2'd1,
    UC_STORE = 2'd2,
    UC_FP    = 2'd3
  } unit_class_e;

  // station index -> unit class; any index past the fixed ones is floating point
  function automatic unit_class_e class_of(input int idx);
    case (idx)
      0:       return UC_ALU;
      1:       return UC_LOAD;
      2:       return UC_STORE;
      default: return UC_FP;
    endcase
  endfunction
endpackage

// File: rtl/rs_entry.sv
module rs_entry #(
  parameter int XLEN = 16,
  parameter int OPW  = 4,
  parameter int RW   = 3,
  parameter int TAGW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            alloc,
  input  logic [OPW-1:0]  a_op,
  input  logic            a_has_dst,
  input  logic [RW-1:0]   a_dst,
  input  logic [TAGW-1:0] a_t1,
  input  logic [TAGW-1:0] a_t2,
  input  logic [XLEN-1:0] a_v1,
  input  logic [XLEN-1:0] a_v2,
  input  logic            bus_valid,
  input  logic [TAGW-1:0] bus_tag,
  input  logic [XLEN-1:0] bus_value,
  input  logic            grant_issue,
  input  logic            fu_done,
  input  logic [XLEN-1:0] fu_value,
  input  logic            release_i,
  output logic            busy_o,
  output logic            issue_rdy_o,
  output logic            done_o,
  output logic            has_dst_o,
  output logic [RW-1:0]   dst_o,
  output logic [OPW-1:0]  op_o,
  output logic [XLEN-1:0] opnd1_o,
  output logic [XLEN-1:0] opnd2_o,
  output logic [XLEN-1:0] result_o
);
  logic            busy, issued, done, has_dst;
  logic [RW-1:0]   dst;
  logic [OPW-1:0]  op;
  logic [TAGW-1:0] t1, t2;
  logic [XLEN-1:0] v1, v2, result;
  logic            hit1, hit2;

  assign hit1 = bus_valid && (t1 != '0) && (bus_tag == t1);
  assign hit2 = bus_valid && (t2 != '0) && (bus_tag == t2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; issued <= 1'b0; done <= 1'b0; has_dst <= 1'b0;
      dst <= '0; op <= '0; t1 <= '0; t2 <= '0;
      v1 <= '0; v2 <= '0; result <= '0;
    end else begin
      if (busy && hit1) begin t1 <= '0; v1 <= bus_value; end
      if (busy && hit2) begin t2 <= '0; v2 <= bus_value; end
      if (grant_issue) issued <= 1'b1;
      if (busy && issued && !done && fu_done) begin
        done   <= 1'b1;
        result <= fu_value;
      end
      if (release_i) begin busy <= 1'b0; issued <= 1'b0; done <= 1'b0; end
      if (alloc) begin
        busy <= 1'b1; issued <= 1'b0; done <= 1'b0;
        op <= a_op; has_dst <= a_has_dst; dst <= a_dst;
        t1 <= a_t1; t2 <= a_t2; v1 <= a_v1; v2 <= a_v2;
      end
    end
  end

  assign busy_o      = busy;
  assign done_o      = done;
  assign has_dst_o   = has_dst;
  assign dst_o       = dst;
  assign op_o        = op;
  assign result_o    = result;
  assign issue_rdy_o = busy && !issued && ((t1 == '0) || hit1) && ((t2 == '0) || hit2);
  assign opnd1_o     = (t1 == '0) ? v1 : bus_value;
  assign opnd2_o     = (t2 == '0) ? v2 : bus_value;

  // R2 / R9: allocation only lands on a free or freeing station
  p_alloc_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |-> (!busy || release_i));
  // R4: a matching broadcast fills the pending source
  p_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && hit1 && !alloc && !release_i) |=> (t1 == '0) && (v1 == $past(bus_value)));
  // R8: the selector grants only a station with all operands present
  p_issue_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    grant_issue |-> issue_rdy_o);
  // R11: a result is only latched after the instruction was issued
  p_done_issued_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> issued);
endmodule

// File: rtl/age_order.sv
module age_order #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] alloc_vec,
  input  logic [N-1:0] keep_vec,
  input  logic [N-1:0] req_iss,
  input  logic [N-1:0] req_bus,
  output logic [N-1:0] gnt_iss,
  output logic [N-1:0] gnt_bus
);
  localparam logic [N-1:0] ONE = N'(1);

  // older_q[i][j] set: station j entered before station i
  logic [N-1:0] older_q [N];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) older_q[i] <= '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        if (alloc_vec[i]) older_q[i] <= keep_vec & ~(ONE << i);
        else              older_q[i] <= older_q[i] & ~alloc_vec;
      end
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_pick
    assign gnt_iss[g] = req_iss[g] && ((older_q[g] & req_iss) == '0);
    assign gnt_bus[g] = req_bus[g] && ((older_q[g] & req_bus) == '0);
  end

  p_bus_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_bus));
  p_iss_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_iss));
  p_bus_served_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_bus != '0) |-> (gnt_bus != '0));
endmodule

// File: rtl/map_regfile.sv
module map_regfile #(
  parameter int NREG = 8,
  parameter int XLEN = 16,
  parameter int TAGW = 3,
  localparam int RW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [RW-1:0]   rd1_addr,
  input  logic [RW-1:0]   rd2_addr,
  input  logic [RW-1:0]   obs_addr,
  output logic [TAGW-1:0] rd1_tag,
  output logic [XLEN-1:0] rd1_val,
  output logic [TAGW-1:0] rd2_tag,
  output logic [XLEN-1:0] rd2_val,
  output logic [TAGW-1:0] obs_tag,
  output logic [XLEN-1:0] obs_val,
  input  logic            ren_en,
  input  logic [RW-1:0]   ren_reg,
  input  logic [TAGW-1:0] ren_tag,
  input  logic            wb_en,
  input  logic [RW-1:0]   wb_reg,
  input  logic [TAGW-1:0] wb_tag,
  input  logic [XLEN-1:0] wb_value
);
  logic [TAGW-1:0] map_q [NREG];
  logic [XLEN-1:0] rf_q  [NREG];
  logic            wb_hit;

  assign wb_hit = wb_en && (map_q[wb_reg] == wb_tag);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < NREG; k++) begin
        map_q[k] <= '0;
        rf_q[k]  <= XLEN'(k * 16);
      end
    end else begin
      if (wb_hit) begin
        rf_q[wb_reg]  <= wb_value;
        map_q[wb_reg] <= '0;
      end
      if (ren_en) map_q[ren_reg] <= ren_tag;
    end
  end

  assign rd1_tag = map_q[rd1_addr];
  assign rd1_val = rf_q[rd1_addr];
  assign rd2_tag = map_q[rd2_addr];
  assign rd2_val = rf_q[rd2_addr];
  assign obs_tag = map_q[obs_addr];
  assign obs_val = rf_q[obs_addr];

  p_rename_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ren_en |=> map_q[$past(ren_reg)] == $past(ren_tag));
  p_stale_wb_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_en && !wb_hit) |=> rf_q[$past(wb_reg)] == $past(rf_q[wb_reg]));
  p_wb_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_hit && !(ren_en && ren_reg == wb_reg)) |=>
      (map_q[$past(wb_reg)] == '0) && (rf_q[$past(wb_reg)] == $past(wb_value)));
endmodule

// File: rtl/rs_sched.sv
module rs_sched #(
  parameter int XLEN = 16,
  parameter int OPW  = 4,
  parameter int NREG = 8,
  parameter int NRS  = 5,
  localparam int RW   = $clog2(NREG),
  localparam int TAGW = $clog2(NRS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                disp_valid,
  output logic                disp_ready,
  input  logic [1:0]          disp_class,
  input  logic [OPW-1:0]      disp_op,
  input  logic                disp_has_dst,
  input  logic [RW-1:0]       disp_dst,
  input  logic [RW-1:0]       disp_src1,
  input  logic [RW-1:0]       disp_src2,
  output logic                iss_valid,
  input  logic                iss_ready,
  output logic [TAGW-1:0]     iss_tag,
  output logic [OPW-1:0]      iss_op,
  output logic [XLEN-1:0]     iss_opnd1,
  output logic [XLEN-1:0]     iss_opnd2,
  input  logic [NRS-1:0]      fu_done,
  input  logic [NRS*XLEN-1:0] fu_result,
  output logic                cdb_valid,
  output logic [TAGW-1:0]     cdb_tag,
  output logic [XLEN-1:0]     cdb_value,
  input  logic [RW-1:0]       obs_reg,
  output logic [TAGW-1:0]     obs_tag,
  output logic [XLEN-1:0]     obs_value
);
  import rs_sched_pkg::*;

  logic [NRS-1:0] busy, rdy, done, has_dst, release_v, cand, pick, alloc_vec;
  logic [NRS-1:0] req_bus, gnt_bus, gnt_iss;
  logic [RW-1:0]   st_dst [NRS];
  logic [OPW-1:0]  st_op  [NRS];
  logic [XLEN-1:0] st_o1 [NRS], st_o2 [NRS], st_res [NRS];
  logic [TAGW-1:0] new_tag, m1_tag, m2_tag, s1_tag, s2_tag;
  logic [XLEN-1:0] m1_val, m2_val, s1_val, s2_val;
  logic [RW-1:0]   wb_reg;
  logic            disp_fire;

  // lowest free station of the requested class; a freeing one counts as free
  always_comb begin
    pick = '0;
    new_tag = '0;
    for (int i = NRS - 1; i >= 0; i--) begin
      cand[i] = (class_of(i) == unit_class_e'(disp_class)) && (!busy[i] || release_v[i]);
    end
    for (int i = NRS - 1; i >= 0; i--) begin
      if (cand[i]) begin
        pick    = '0;
        pick[i] = 1'b1;
        new_tag = TAGW'(i + 1);
      end
    end
  end

  assign disp_ready = |cand;
  assign disp_fire  = disp_valid && disp_ready;
  assign alloc_vec  = disp_fire ? pick : '0;

  // source resolution: register file, same-cycle broadcast, or producer tag
  always_comb begin
    s1_tag = m1_tag; s1_val = '0;
    s2_tag = m2_tag; s2_val = '0;
    if (m1_tag == '0) s1_val = m1_val;
    else if (cdb_valid && cdb_tag == m1_tag) begin s1_tag = '0; s1_val = cdb_value; end
    if (m2_tag == '0) s2_val = m2_val;
    else if (cdb_valid && cdb_tag == m2_tag) begin s2_tag = '0; s2_val = cdb_value; end
  end

  for (genvar g = 0; g < NRS; g++) begin : g_rs
    rs_entry #(.XLEN(XLEN), .OPW(OPW), .RW(RW), .TAGW(TAGW)) u_rs (
      .clk(clk), .rst_n(rst_n), .alloc(alloc_vec[g]),
      .a_op(disp_op), .a_has_dst(disp_has_dst), .a_dst(disp_dst),
      .a_t1(s1_tag), .a_t2(s2_tag), .a_v1(s1_val), .a_v2(s2_val),
      .bus_valid(cdb_valid), .bus_tag(cdb_tag), .bus_value(cdb_value),
      .grant_issue(gnt_iss[g] && iss_ready),
      .fu_done(fu_done[g]), .fu_value(fu_result[g*XLEN +: XLEN]),
      .release_i(release_v[g]),
      .busy_o(busy[g]), .issue_rdy_o(rdy[g]), .done_o(done[g]),
      .has_dst_o(has_dst[g]), .dst_o(st_dst[g]), .op_o(st_op[g]),
      .opnd1_o(st_o1[g]), .opnd2_o(st_o2[g]), .result_o(st_res[g])
    );
    assign req_bus[g]   = done[g] && has_dst[g];
    assign release_v[g] = gnt_bus[g] || (done[g] && !has_dst[g]);

    p_loser_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_bus[g] && !gnt_bus[g]) |=> req_bus[g]);
  end

  age_order #(.N(NRS)) u_age (
    .clk(clk), .rst_n(rst_n), .alloc_vec(alloc_vec),
    .keep_vec(busy & ~release_v), .req_iss(rdy), .req_bus(req_bus),
    .gnt_iss(gnt_iss), .gnt_bus(gnt_bus)
  );

  always_comb begin
    cdb_tag = '0; cdb_value = '0; wb_reg = '0;
    iss_tag = '0; iss_op = '0; iss_opnd1 = '0; iss_opnd2 = '0;
    for (int i = 0; i < NRS; i++) begin
      if (gnt_bus[i]) begin
        cdb_tag   = TAGW'(i + 1);
        cdb_value = st_res[i];
        wb_reg    = st_dst[i];
      end
      if (gnt_iss[i]) begin
        iss_tag   = TAGW'(i + 1);
        iss_op    = st_op[i];
        iss_opnd1 = st_o1[i];
        iss_opnd2 = st_o2[i];
      end
    end
  end
  assign cdb_valid = |gnt_bus;
  assign iss_valid = |gnt_iss;

  map_regfile #(.NREG(NREG), .XLEN(XLEN), .TAGW(TAGW)) u_map (
    .clk(clk), .rst_n(rst_n),
    .rd1_addr(disp_src1), .rd2_addr(disp_src2), .obs_addr(obs_reg),
    .rd1_tag(m1_tag), .rd1_val(m1_val), .rd2_tag(m2_tag), .rd2_val(m2_val),
    .obs_tag(obs_tag), .obs_val(obs_value),
    .ren_en(disp_fire && disp_has_dst), .ren_reg(disp_dst), .ren_tag(new_tag),
    .wb_en(cdb_valid), .wb_reg(wb_reg), .wb_tag(cdb_tag), .wb_value(cdb_value)
  );

  p_bus_carries_dst_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cdb_valid |-> (cdb_tag != '0));
  p_dispatch_needs_room_r2: assert property (@(posedge clk) disable iff (!rst_n)
    disp_fire |=> ($countones(busy) >= 1));
endmodule

// File: tb/rs_sched_tb_top.sv
module rs_sched_tb_top;
  localparam int XLEN = 16;
  localparam int NRS  = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic disp_valid = 1'b0, disp_ready, disp_has_dst = 1'b0;
  logic [1:0] disp_class = '0;
  logic [3:0] disp_op = '0;
  logic [2:0] disp_dst = '0, disp_src1 = '0, disp_src2 = '0;
  logic iss_valid, iss_ready = 1'b0;
  logic [2:0] iss_tag;
  logic [3:0] iss_op;
  logic [15:0] iss_opnd1, iss_opnd2;
  logic [NRS-1:0] fu_done = '0;
  logic [NRS*XLEN-1:0] fu_result = '0;
  logic cdb_valid;
  logic [2:0] cdb_tag;
  logic [15:0] cdb_value;
  logic [2:0] obs_reg = '0;
  logic [2:0] obs_tag;
  logic [15:0] obs_value;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  rs_sched dut_i (
    .clk(clk), .rst_n(rst_n),
    .disp_valid(disp_valid), .disp_ready(disp_ready), .disp_class(disp_class),
    .disp_op(disp_op), .disp_has_dst(disp_has_dst), .disp_dst(disp_dst),
    .disp_src1(disp_src1), .disp_src2(disp_src2),
    .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_tag(iss_tag), .iss_op(iss_op),
    .iss_opnd1(iss_opnd1), .iss_opnd2(iss_opnd2),
    .fu_done(fu_done), .fu_result(fu_result),
    .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_value(cdb_value),
    .obs_reg(obs_reg), .obs_tag(obs_tag), .obs_value(obs_value)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic disp(input logic [1:0] cls, input logic hd, input logic [2:0] dst,
                      input logic [2:0] s1, input logic [2:0] s2, input string req);
    disp_class = cls; disp_has_dst = hd; disp_dst = dst;
    disp_src1 = s1; disp_src2 = s2; disp_op = {2'b10, cls}; disp_valid = 1'b1;
    #1;
    chk(req, "disp_ready", disp_ready, 1);
    step();
    disp_valid = 1'b0;
    #1;
  endtask

  task automatic take_issue(input logic [2:0] tag, input logic [15:0] o1, input logic [15:0] o2, input string req);
    chk(req, "iss_valid", iss_valid, 1);
    chk(req, "iss_tag", iss_tag, tag);
    chk(req, "iss_opnd1", iss_opnd1, o1);
    chk(req, "iss_opnd2", iss_opnd2, o2);
    iss_ready = 1'b1;
    step();
    iss_ready = 1'b0;
    #1;
  endtask

  task automatic finish_unit(input int idx, input logic [15:0] val);
    fu_done[idx] = 1'b1;
    fu_result[idx*XLEN +: XLEN] = val;
    step();
    fu_done = '0;
    #1;
  endtask

  task automatic expect_reg(input logic [2:0] r, input logic [2:0] tag, input logic [15:0] val, input string req);
    obs_reg = r;
    #1;
    chk(req, "obs_tag", obs_tag, tag);
    chk(req, "obs_value", obs_value, val);
  endtask

  task automatic expect_bus(input logic v, input logic [2:0] tag, input logic [15:0] val, input string req);
    chk(req, "cdb_valid", cdb_valid, v);
    if (v) begin
      chk(req, "cdb_tag", cdb_tag, tag);
      chk(req, "cdb_value", cdb_value, val);
    end
  endtask

  task automatic t_reset();
    for (int c = 0; c < 4; c++) begin
      disp_class = 2'(c);
      #1;
      chk("R1", "disp_ready per class", disp_ready, 1);
    end
    chk("R1", "iss_valid", iss_valid, 0);
    chk("R1", "cdb_valid", cdb_valid, 0);
    expect_reg(3'd3, 3'd0, 16'd48, "R1");
    expect_reg(3'd7, 3'd0, 16'd112, "R1");
  endtask

  task automatic t_basic();
    disp(2'd0, 1'b1, 3'd1, 3'd2, 3'd3, "R2");
    expect_reg(3'd1, 3'd1, 16'd16, "R3");
    take_issue(3'd1, 16'd32, 16'd48, "R4");
    chk("R8", "iss_valid after accept", iss_valid, 0);
    finish_unit(0, 16'h1234);
    expect_bus(1'b1, 3'd1, 16'h1234, "R5");
    step();
    expect_bus(1'b0, 3'd0, 16'h0, "R5");
    expect_reg(3'd1, 3'd0, 16'h1234, "R5");
  endtask

  task automatic t_dependent();
    disp(2'd1, 1'b1, 3'd4, 3'd1, 3'd0, "R2");
    disp(2'd3, 1'b1, 3'd5, 3'd4, 3'd0, "R4");
    take_issue(3'd2, 16'h1234, 16'h0, "R8");
    chk("R4", "waiting station not issued", iss_valid, 0);
    finish_unit(3, 16'hDEAD);
    expect_bus(1'b0, 3'd0, 16'h0, "R11");
    finish_unit(1, 16'h0050);
    expect_bus(1'b1, 3'd2, 16'h0050, "R4");
    take_issue(3'd4, 16'h0050, 16'h0, "R8");
    expect_reg(3'd4, 3'd0, 16'h0050, "R5");
    finish_unit(3, 16'h00AA);
    expect_bus(1'b1, 3'd4, 16'h00AA, "R11");
    step();
    expect_reg(3'd5, 3'd0, 16'h00AA, "R5");
  endtask

  task automatic t_waw();
    disp(2'd3, 1'b1, 3'd6, 3'd0, 3'd0, "R2");
    disp(2'd3, 1'b1, 3'd6, 3'd0, 3'd0, "R3");
    expect_reg(3'd6, 3'd5, 16'd96, "R3");
    disp_class = 2'd3;
    #1;
    chk("R2", "fp class full", disp_ready, 0);
    disp_class = 2'd0;
    #1;
    chk("R2", "alu class free", disp_ready, 1);
    take_issue(3'd4, 16'h0, 16'h0, "R8");
    take_issue(3'd5, 16'h0, 16'h0, "R8");
    finish_unit(3, 16'h1111);
    expect_bus(1'b1, 3'd4, 16'h1111, "R5");
    step();
    expect_reg(3'd6, 3'd5, 16'd96, "R5");
    finish_unit(4, 16'h2222);
    expect_bus(1'b1, 3'd5, 16'h2222, "R5");
    step();
    expect_reg(3'd6, 3'd0, 16'h2222, "R5");
  endtask

  task automatic t_store();
    disp(2'd2, 1'b0, 3'd0, 3'd1, 3'd5, "R2");
    disp_class = 2'd2;
    #1;
    chk("R2", "store class full", disp_ready, 0);
    take_issue(3'd3, 16'h1234, 16'h00AA, "R8");
    finish_unit(2, 16'h0);
    expect_bus(1'b0, 3'd0, 16'h0, "R6");
    disp(2'd2, 1'b0, 3'd0, 3'd5, 3'd6, "R9");
    take_issue(3'd3, 16'h00AA, 16'h2222, "R9");
    finish_unit(2, 16'h0);
    expect_bus(1'b0, 3'd0, 16'h0, "R6");
    step();
    disp_class = 2'd2;
    #1;
    chk("R6", "store station freed", disp_ready, 1);
  endtask

  task automatic t_age();
    disp(2'd3, 1'b1, 3'd3, 3'd0, 3'd0, "R2");
    disp(2'd0, 1'b1, 3'd2, 3'd0, 3'd0, "R2");
    take_issue(3'd4, 16'h0, 16'h0, "R8");
    take_issue(3'd1, 16'h0, 16'h0, "R8");
    fu_done = 5'b01001;
    fu_result[0*XLEN +: XLEN] = 16'h00A1;
    fu_result[3*XLEN +: XLEN] = 16'h00F4;
    step();
    fu_done = '0;
    #1;
    expect_bus(1'b1, 3'd4, 16'h00F4, "R7");
    step();
    expect_bus(1'b1, 3'd1, 16'h00A1, "R7");
    step();
    expect_bus(1'b0, 3'd0, 16'h0, "R7");
    expect_reg(3'd3, 3'd0, 16'h00F4, "R7");
    expect_reg(3'd2, 3'd0, 16'h00A1, "R7");
  endtask

  task automatic t_bypass();
    disp(2'd1, 1'b1, 3'd7, 3'd0, 3'd0, "R2");
    take_issue(3'd2, 16'h0, 16'h0, "R8");
    finish_unit(1, 16'h0777);
    expect_bus(1'b1, 3'd2, 16'h0777, "R10");
    disp(2'd0, 1'b1, 3'd1, 3'd7, 3'd0, "R10");
    take_issue(3'd1, 16'h0777, 16'h0, "R10");
    finish_unit(0, 16'h0888);
    step();
    expect_reg(3'd1, 3'd0, 16'h0888, "R10");
    expect_reg(3'd7, 3'd0, 16'h0777, "R10");
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    rst_n = 1'b1;
    #1;
    t_reset();
    t_basic();
    t_dependent();
    t_waw();
    t_store();
    t_age();
    t_bypass();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule